// File: doc/BRIEF.md
# Bit-Mode Port Control Decoder

This block holds the programming state of one eight-line parallel port and carries out its bit-control behaviour. A host writes bytes into it with a strobe and a control/data select. Data bytes load the port's output register. Control bytes are decoded by their low bits into one of four word types: mode word, interrupt-condition word, enable/disable word and vector word. Bytes that match none of these are ignored.

A small sequencer decides how each control byte is read. Choosing bit-control mode makes the next control byte the line-direction word. Setting the mask-follows flag in an interrupt-condition word makes the next control byte the mask. The sequencer has three states. `SEQ_IDLE` decodes by word type. `SEQ_DIR` takes any control byte as the direction word and returns to `SEQ_IDLE`. `SEQ_MASK` takes any control byte as the mask and returns to `SEQ_IDLE`. Only two transitions leave `SEQ_IDLE`: a bit-mode word leads to `SEQ_DIR`, and an interrupt-condition word with mask-follows set leads to `SEQ_MASK`.

In bit-control mode the block compares the monitored input lines against the programmed level, combining them with AND or OR. When that comparison turns true it raises a pending interrupt, which is presented on `irq` only while the enable is live. The block also forms the byte returned to the host on a read.

Top module: `bitport_ctrl`

## Requirements
- R1: A control byte whose low nibble is 1111 is a mode word. Bits 7:6 set `port_mode`: 00 output, 01 input, 10 bidirectional, 11 bit control.
- R2: After a mode word with bits 7:6 = 11, the next control byte loads `port_dir`, whatever its value. In `port_dir`, 1 marks an input line and 0 an output line. Data writes in between do not consume this slot; they only load `port_out`.
- R3: A control byte whose low nibble is 0111 is an interrupt-condition word. Its bits are: bit 7 enable, bit 6 AND function (0 = OR), bit 5 active-high (0 = active-low), bit 4 mask-follows. With bit 4 set, the next control byte loads the 8-bit mask.
- R4: A line is monitored only when its `port_dir` bit is 1 and its mask bit is 0. OR matches when any monitored line is at the active level. AND matches when every monitored line is at the active level. With no monitored line there is no match.
- R5: In bit-control mode, a change of the match from false to true sets the pending interrupt. A one-cycle `irq_ack` clears it. `irq` is high while the interrupt is pending and the enable is live.
- R6: An interrupt-condition word with mask-follows set clears the pending interrupt.
- R7: Writing an interrupt-condition or enable/disable word drops the live enable at once. If the written enable bit is 1, the enable becomes live at the first `m1_pulse` seen in a later cycle.
- R8: A control byte whose low nibble is 0011 is an enable/disable word. Its bit 7 is the new enable. It leaves the function, level, mask and pending state unchanged.
- R9: A control byte with bit 0 clear loads `int_vector` from bits 7:1, with bit 0 held at 0.
- R10: `rd_data` depends on the mode. In bit mode it is `port_out` on output lines and the sampled pins on input lines. In output mode it is `port_out`. Otherwise it is the sampled pins. Pins are sampled on each clock while `rd_en` is low, and the sample is held while `rd_en` stays high.
- R11: After reset: `port_mode` is 01, `port_dir` is all ones, the mask is all ones, `int_vector` is 0, the enable is off, nothing is pending and the sequencer is in `SEQ_IDLE`.
- R12: A control byte in `SEQ_IDLE` that matches no word type changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| cmd_sel | input | 1 | 1 = control byte, 0 = data byte |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Host read, held high for the access |
| m1_pulse | input | 1 | One-cycle marker of a machine-cycle start |
| irq_ack | input | 1 | One-cycle clear of the pending interrupt |
| pins_in | input | 8 | Levels on the port lines |
| port_out | output | 8 | Output register |
| port_dir | output | 8 | Line directions, 1 = input |
| port_mode | output | 2 | Current mode |
| int_vector | output | 8 | Interrupt vector, bit 0 always 0 |
| irq | output | 1 | Match interrupt request |
| rd_data | output | 8 | Byte returned to the host |

## Verification
A sequencer stuck in the wrong state shows up on the very next control byte: it loads `port_dir`, the mask or the vector in place of another, and the change is visible on `port_dir` or `int_vector` one clock later. A wrong pending flag or live enable appears on `irq` in the cycle after the match edge, the acknowledge or the `m1_pulse`. The tests order these events so that a missing clear or an early enable produces a wrong `irq` level. A read sample that is not held shows up on `rd_data` as soon as the pins move during a read.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    localparam int BYTE_W = 8;
    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_DIR  = 2'd1,
        SEQ_MASK = 2'd2
    } seq_t;

    typedef enum logic [2:0] {
        WT_NONE,
        WT_MODE,
        WT_ICW,
        WT_EDW,
        WT_VEC
    } word_t;

    localparam logic [MODE_W-1:0] MODE_OUT   = 2'b00;
    localparam logic [MODE_W-1:0] MODE_IN    = 2'b01;
    localparam logic [MODE_W-1:0] MODE_BIDIR = 2'b10;
    localparam logic [MODE_W-1:0] MODE_BIT   = 2'b11;

    // Word-type decode from the low bits; mode pattern is checked first
    // because it also satisfies the interrupt-condition pattern.
    function automatic word_t classify(input logic [BYTE_W-1:0] b);
        if (b[3:0] == 4'b1111)      return WT_MODE;
        else if (b[2:0] == 3'b111)  return WT_ICW;
        else if (b[3:0] == 4'b0011) return WT_EDW;
        else if (!b[0])             return WT_VEC;
        else                        return WT_NONE;
    endfunction

endpackage

// File: rtl/bpc_seq.sv
module bpc_seq
    import bpc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                cmd_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                m1_pulse,
    output logic [MODE_W-1:0]   mode_q,
    output logic [BYTE_W-1:0]   dir_q,
    output logic [BYTE_W-1:0]   mask_q,
    output logic [BYTE_W-1:0]   vec_q,
    output logic                and_fn_q,
    output logic                act_hi_q,
    output logic                en_live_q,
    output logic                clr_pend,
    output seq_t                st_q
);

    seq_t  st_d;
    word_t wt;
    logic  ctl_wr;
    logic  arm_q;

    assign ctl_wr = wr_en & cmd_sel;
    assign wt     = classify(wr_data);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE: begin
                if (ctl_wr && wt == WT_MODE && wr_data[7:6] == MODE_BIT)
                    st_d = SEQ_DIR;
                else if (ctl_wr && wt == WT_ICW && wr_data[4])
                    st_d = SEQ_MASK;
            end
            SEQ_DIR:  if (ctl_wr) st_d = SEQ_IDLE;
            SEQ_MASK: if (ctl_wr) st_d = SEQ_IDLE;
            default:  st_d = SEQ_IDLE;
        endcase
    end

    assign clr_pend = ctl_wr && (st_q == SEQ_IDLE) && (wt == WT_ICW) && wr_data[4];

    // programming registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_IN;
            dir_q     <= '1;
            mask_q    <= '1;
            vec_q     <= '0;
            and_fn_q  <= 1'b0;
            act_hi_q  <= 1'b0;
            en_live_q <= 1'b0;
            arm_q     <= 1'b0;
        end else if (ctl_wr) begin
            unique case (st_q)
                SEQ_IDLE: begin
                    unique case (wt)
                        WT_MODE: mode_q <= wr_data[7:6];
                        WT_ICW: begin
                            and_fn_q  <= wr_data[6];
                            act_hi_q  <= wr_data[5];
                            en_live_q <= 1'b0;
                            arm_q     <= wr_data[7];
                        end
                        WT_EDW: begin
                            en_live_q <= 1'b0;
                            arm_q     <= wr_data[7];
                        end
                        WT_VEC:  vec_q <= {wr_data[BYTE_W-1:1], 1'b0};
                        default: ;
                    endcase
                end
                SEQ_DIR:  dir_q  <= wr_data;
                SEQ_MASK: mask_q <= wr_data;
                default:  ;
            endcase
        end else if (m1_pulse && arm_q) begin
            en_live_q <= 1'b1;
            arm_q     <= 1'b0;
        end
    end

endmodule

// File: rtl/bpc_match.sv
module bpc_match
    import bpc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode,
    input  logic [BYTE_W-1:0]   dir,
    input  logic [BYTE_W-1:0]   mask,
    input  logic                and_fn,
    input  logic                act_hi,
    input  logic                en_live,
    input  logic                clr_pend,
    input  logic                ack,
    input  logic [BYTE_W-1:0]   pins,
    output logic                irq
);

    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] hit;
    logic              match;
    logic              bit_mode;
    logic              match_q;
    logic              pend_q;

    // per-line monitor and level test
    for (genvar i = 0; i < BYTE_W; i++) begin : g_line
        assign mon[i] = dir[i] & ~mask[i];
        assign hit[i] = mon[i] & (act_hi ? pins[i] : ~pins[i]);
    end

    assign bit_mode = (mode == MODE_BIT);
    assign match    = (|mon) && (and_fn ? (hit == mon) : (|hit));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            match_q <= bit_mode && match;
            if (clr_pend || ack)
                pend_q <= 1'b0;
            else if (bit_mode && match && !match_q)
                pend_q <= 1'b1;
        end
    end

    assign irq = pend_q & en_live;

endmodule

// File: rtl/bpc_data.sv
module bpc_data
    import bpc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                cmd_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [BYTE_W-1:0]   pins,
    input  logic [MODE_W-1:0]   mode,
    input  logic [BYTE_W-1:0]   dir,
    output logic [BYTE_W-1:0]   out_q,
    output logic [BYTE_W-1:0]   rd_data
);

    logic [BYTE_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            hold_q <= '0;
        end else begin
            if (wr_en && !cmd_sel) out_q <= wr_data;
            if (!rd_en)            hold_q <= pins;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_BIT: rd_data = (out_q & ~dir) | (hold_q & dir);
            MODE_OUT: rd_data = out_q;
            default:  rd_data = hold_q;
        endcase
    end

endmodule

// File: rtl/bitport_ctrl.sv
module bitport_ctrl
    import bpc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                cmd_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic                m1_pulse,
    input  logic                irq_ack,
    input  logic [BYTE_W-1:0]   pins_in,
    output logic [BYTE_W-1:0]   port_out,
    output logic [BYTE_W-1:0]   port_dir,
    output logic [MODE_W-1:0]   port_mode,
    output logic [BYTE_W-1:0]   int_vector,
    output logic                irq,
    output logic [BYTE_W-1:0]   rd_data
);

    logic [BYTE_W-1:0] mask_w;
    logic              and_w;
    logic              hi_w;
    logic              live_w;
    logic              clr_w;
    seq_t              st_w;

    bpc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .cmd_sel   (cmd_sel),
        .wr_data   (wr_data),
        .m1_pulse  (m1_pulse),
        .mode_q    (port_mode),
        .dir_q     (port_dir),
        .mask_q    (mask_w),
        .vec_q     (int_vector),
        .and_fn_q  (and_w),
        .act_hi_q  (hi_w),
        .en_live_q (live_w),
        .clr_pend  (clr_w),
        .st_q      (st_w)
    );

    bpc_match u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (port_mode),
        .dir      (port_dir),
        .mask     (mask_w),
        .and_fn   (and_w),
        .act_hi   (hi_w),
        .en_live  (live_w),
        .clr_pend (clr_w),
        .ack      (irq_ack),
        .pins     (pins_in),
        .irq      (irq)
    );

    bpc_data u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .cmd_sel (cmd_sel),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .pins    (pins_in),
        .mode    (port_mode),
        .dir     (port_dir),
        .out_q   (port_out),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/bitport_ctrl_chk.sv
module bitport_ctrl_chk
    import bpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              cmd_sel,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic              irq,
    input  logic [7:0]        rd_data,
    input  logic [7:0]        port_dir,
    input  seq_t              seq_st
);

    logic ctl;
    assign ctl = wr_en & cmd_sel;

    p_mode3_to_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SEQ_IDLE && ctl && wr_data[3:0] == 4'hF && wr_data[7:6] == 2'b11)
        |=> (seq_st == SEQ_DIR));

    p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SEQ_DIR && ctl)
        |=> (seq_st == SEQ_IDLE && port_dir == $past(wr_data)));

    p_mask_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SEQ_IDLE && ctl && wr_data[3:0] == 4'b0111 && wr_data[4])
        |=> (seq_st == SEQ_MASK));

    p_mask_word_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SEQ_IDLE && ctl && wr_data[3:0] == 4'b0111 && wr_data[4])
        |=> !irq);

    p_enable_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SEQ_IDLE && ctl && (wr_data[3:0] == 4'b0111 || wr_data[3:0] == 4'b0011))
        |=> !irq);

    p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && !$past(wr_en))
        |-> (rd_data == $past(rd_data)));

endmodule

bind bitport_ctrl bitport_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .cmd_sel  (cmd_sel),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .irq      (irq),
    .rd_data  (rd_data),
    .port_dir (port_dir),
    .seq_st   (st_w)
);

// File: tb/bitport_ctrl_bench.sv
module bitport_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       cmd_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       m1_pulse = 1'b0;
    logic       irq_ack = 1'b0;
    logic [7:0] pins_in = '0;
    logic [7:0] port_out, port_dir, int_vector, rd_data;
    logic [1:0] port_mode;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitport_ctrl u_bitport_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_sel(cmd_sel),
        .wr_data(wr_data), .rd_en(rd_en), .m1_pulse(m1_pulse),
        .irq_ack(irq_ack), .pins_in(pins_in), .port_out(port_out),
        .port_dir(port_dir), .port_mode(port_mode), .int_vector(int_vector),
        .irq(irq), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] b);
        wr_en = 1'b1; cmd_sel = 1'b1; wr_data = b;
        tick();
        wr_en = 1'b0; cmd_sel = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] b);
        wr_en = 1'b1; cmd_sel = 1'b0; wr_data = b;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic m1();
        m1_pulse = 1'b1; tick(); m1_pulse = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] p);
        pins_in = p; tick();
    endtask

    task automatic t_reset();
        chk("R11 mode", {6'd0, port_mode}, 8'h01);
        chk("R11 dir", port_dir, 8'hFF);
        chk("R11 vector", int_vector, 8'h00);
        chk("R11 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_modes();
        wr_ctl(8'h0F);
        chk("R1 output mode", {6'd0, port_mode}, 8'h00);
        wr_dat(8'h5A);
        chk("R10 output read", rd_data, 8'h5A);
        wr_ctl(8'h4F);
        chk("R1 input mode", {6'd0, port_mode}, 8'h01);
        set_pins(8'h77);
        chk("R10 input read", rd_data, 8'h77);
        wr_ctl(8'h8F);
        chk("R1 bidir mode", {6'd0, port_mode}, 8'h02);
    endtask

    task automatic t_dir_seq();
        wr_ctl(8'hCF);
        wr_dat(8'h11);
        wr_ctl(8'h0F);
        chk("R2 dir loaded", port_dir, 8'h0F);
        chk("R2 mode kept", {6'd0, port_mode}, 8'h03);
        chk("R2 data write", port_out, 8'h11);
    endtask

    task automatic t_ignored();
        wr_ctl(8'h05);
        wr_ctl(8'h0B);
        chk("R12 mode", {6'd0, port_mode}, 8'h03);
        chk("R12 dir", port_dir, 8'h0F);
        chk("R12 vector", int_vector, 8'h00);
    endtask

    task automatic t_vector();
        wr_ctl(8'hFE);
        chk("R9 vector", int_vector, 8'hFE);
        wr_ctl(8'h22);
        chk("R9 vector2", int_vector, 8'h22);
    endtask

    task automatic t_read_mix();
        wr_ctl(8'hCF); wr_ctl(8'hF0);
        wr_dat(8'h5A);
        set_pins(8'h3C);
        rd_en = 1'b1;
        pins_in = 8'hFF;
        tick();
        chk("R10 bit read", rd_data, 8'h3A);
        tick();
        chk("R10 held sample", rd_data, 8'h3A);
        rd_en = 1'b0;
        tick();
        chk("R10 resample", rd_data, 8'hFA);
    endtask

    task automatic t_or_high();
        wr_ctl(8'hCF); wr_ctl(8'hFF);
        set_pins(8'h00);
        wr_ctl(8'hB7); wr_ctl(8'hF0);
        m1();
        set_pins(8'h01);
        chk("R5 OR high irq", {7'd0, irq}, 8'h01);
        ack();
        chk("R5 ack clears", {7'd0, irq}, 8'h00);
        set_pins(8'h03);
        chk("R5 no new edge", {7'd0, irq}, 8'h00);
        set_pins(8'h00);
        set_pins(8'h10);
        chk("R4 masked line", {7'd0, irq}, 8'h00);
        set_pins(8'h04);
        chk("R4 OR any line", {7'd0, irq}, 8'h01);
        ack();
    endtask

    task automatic t_and_low();
        wr_ctl(8'hCF); wr_ctl(8'h3F);
        wr_ctl(8'hD7); wr_ctl(8'h0F);
        set_pins(8'h10);
        m1();
        chk("R4 AND partial", {7'd0, irq}, 8'h00);
        set_pins(8'hC0);
        chk("R4 AND low all", {7'd0, irq}, 8'h01);
        ack();
        set_pins(8'h20);
        chk("R4 AND broken", {7'd0, irq}, 8'h00);
        set_pins(8'h00);
        chk("R4 AND again", {7'd0, irq}, 8'h01);
        ack();
    endtask

    task automatic t_no_monitor();
        wr_ctl(8'hCF); wr_ctl(8'hFF);
        wr_ctl(8'hB7); wr_ctl(8'hFF);
        m1();
        set_pins(8'h00);
        set_pins(8'hFF);
        chk("R4 none monitored", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_enable_m1();
        set_pins(8'h00);
        wr_ctl(8'hB7); wr_ctl(8'hF0);
        set_pins(8'h01);
        chk("R7 before m1", {7'd0, irq}, 8'h00);
        tick();
        chk("R7 still off", {7'd0, irq}, 8'h00);
        m1();
        chk("R7 after m1", {7'd0, irq}, 8'h01);
        ack();
    endtask

    task automatic t_edw();
        set_pins(8'h00);
        set_pins(8'h02);
        chk("R8 pre irq", {7'd0, irq}, 8'h01);
        wr_ctl(8'h03);
        chk("R8 disable", {7'd0, irq}, 8'h00);
        wr_ctl(8'h83);
        chk("R8 wait m1", {7'd0, irq}, 8'h00);
        m1();
        chk("R8 pending kept", {7'd0, irq}, 8'h01);
        ack();
        set_pins(8'h00);
        set_pins(8'h20);
        chk("R8 mask kept", {7'd0, irq}, 8'h00);
        set_pins(8'h08);
        chk("R8 OR high kept", {7'd0, irq}, 8'h01);
        ack();
    endtask

    task automatic t_mask_clear();
        set_pins(8'h00);
        set_pins(8'h01);
        chk("R6 pre irq", {7'd0, irq}, 8'h01);
        wr_ctl(8'hA7);
        m1();
        chk("R6 no-mask word keeps", {7'd0, irq}, 8'h01);
        wr_ctl(8'hB7); wr_ctl(8'hF0);
        m1();
        chk("R6 mask word clears", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_modes();
        t_dir_seq();
        t_ignored();
        t_vector();
        t_read_mix();
        t_or_high();
        t_and_low();
        t_no_monitor();
        t_enable_m1();
        t_edw();
        t_mask_clear();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule